// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects eight interrupt request lines and passes the most urgent one to a processor. Software first programs it through a small register port with a one-bit address: a start word, a vector base, an optional cascade word and an optional mode word. After that it can mask lines, issue end-of-interrupt commands and choose whether reads at the low address return pending requests or in-service requests.

Requests are latched in a request register. Priority is fixed, and line 0 is the most urgent. A pending, unmasked request raises the interrupt output only when it is more urgent than every interrupt already in service. When the processor pulses the acknowledge input, the block moves the winning request into service and, one cycle later, presents an 8-bit vector equal to the programmed base plus the line number. If the request vanished before the acknowledge arrived, the block answers with the line-7 vector and marks nothing in service.

The cascade word is kept and exposed on output pins. When the controller is configured as a master it is read as a map of lines with a downstream controller attached. Otherwise its low three bits are a slave identity.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF at address 1, the request and in-service registers are clear, reads at address 0 return the request register, ready is 0, int_out is 0 and vec_valid is 0.
- R2: A write to address 0 with bit 4 set starts initialization. In that word, bit 3 selects level triggering, bit 1 set means no cascade word follows, and bit 0 set means a mode word follows. The following address-1 writes are the base word, then the cascade word (if expected), then the mode word (if expected). ready rises after the last one. int_out stays 0 while ready is 0, and the start word clears both the request and in-service registers.
- R3: In the mode word, bit 2 set configures master. When master, cascade_map shows the cascade word and slave_id is 0. Otherwise cascade_map is 0 and slave_id shows cascade word bits 2:0.
- R4: Outside initialization a write to address 1 loads the mask, and a read at address 1 returns it. A mask bit of 1 keeps that line from raising int_out.
- R5: Line 0 has the highest priority. int_out is 1 only when some unmasked request is more urgent than every in-service bit.
- R6: An acknowledge while int_out is 1 sets the winner's in-service bit and clears its request bit. On the next cycle vec_valid is 1 for one cycle and vec_out is base plus the line number.
- R7: With mode-word bit 1 set (auto end of interrupt), an acknowledge sets no in-service bit.
- R8: A write of 0x60+n to address 0 clears in-service bit n only.
- R9: A write of 0x20 to address 0 clears the most urgent set in-service bit.
- R10: A write of 0x0A to address 0 makes address-0 reads return the request register, and 0x0B makes them return the in-service register. The choice persists across other writes.
- R11: An acknowledge while int_out is 0 returns base+7 and sets no in-service bit, even if line 7 is masked.
- R12: In edge mode a request bit is set by a rising edge and is lost if the line falls before acknowledge. A line held high after acknowledge does not request again. In level mode the request bit follows the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt request lines |
| bus_addr | input | 1 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| ack | input | 1 | Acknowledge strobe |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector returned for an acknowledge |
| vec_valid | output | 1 | vec_out valid for one cycle |
| ready | output | 1 | Initialization complete |
| is_master | output | 1 | Master configuration flag |
| cascade_map | output | 8 | Lines with a downstream controller (master) |
| slave_id | output | 3 | Slave identity (non-master) |

## Verification
On every cycle, the assertions check four things: int_out stays quiet before initialization, a vector appears only after an acknowledge, an acknowledge under auto end of interrupt leaves the in-service register alone, and a real acknowledge adds exactly one in-service bit. A spurious answer is also checked each cycle to carry base+7. Only the bench scenarios can show several behaviours: nesting that blocks a less urgent line, the exact vectors returned, which bit each end-of-interrupt form clears, the persistence of the readback choice, and a request lost before acknowledge.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_in,
  input  logic       bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       ack,
  output logic       int_out,
  output logic [7:0] vec_out,
  output logic       vec_valid,
  output logic       ready,
  output logic       is_master,
  output logic [7:0] cascade_map,
  output logic [2:0] slave_id
);

  typedef enum logic [2:0] {S_IDLE, S_BASE, S_CASC, S_MODE, S_RUN} st_t;

  st_t        st;
  logic [7:0] mask, irr, isr, base, casc, prev;
  logic       level, single, need_mode, aeoi, master, rd_isr;

  wire running   = (st == S_RUN);
  wire wr0       = bus_wr && !bus_addr;
  wire wr1       = bus_wr && bus_addr;
  wire init_go   = wr0 && bus_wdata[4];
  wire cmd_eoi   = wr0 && running && !bus_wdata[4] && !bus_wdata[3];
  wire cmd_sel   = wr0 && running && !bus_wdata[4] && bus_wdata[3];
  wire spec_eoi  = cmd_eoi && (bus_wdata[7:5] == 3'b011);
  wire gen_eoi   = cmd_eoi && (bus_wdata[7:5] == 3'b001);

  wire [7:0] pend    = irr & ~mask;
  wire [7:0] isr_low = isr & (~isr + 8'd1);
  wire [7:0] allow   = (isr == 8'd0) ? 8'hFF : (isr_low - 8'd1);
  wire [7:0] cand    = pend & allow;
  wire [7:0] win_oh  = cand & (~cand + 8'd1);
  wire       take    = ack && running && (cand != 8'd0);
  wire [7:0] rise    = irq_in & ~prev;

  logic [2:0] win;
  always_comb begin
    win = 3'd0;
    for (int i = 7; i >= 0; i--)
      if (cand[i]) win = 3'(i);
  end

  wire [7:0] eoi_clr = spec_eoi ? (8'd1 << bus_wdata[2:0]) :
                       gen_eoi  ? isr_low : 8'd0;
  wire [7:0] isr_set = (take && !aeoi) ? win_oh : 8'd0;
  wire [7:0] irr_clr = (take && !level) ? win_oh : 8'd0;

  assign int_out     = running && (cand != 8'd0);
  assign ready       = running;
  assign is_master   = master;
  assign cascade_map = master ? casc : 8'd0;
  assign slave_id    = master ? 3'd0 : casc[2:0];
  assign bus_rdata   = bus_addr ? mask : (rd_isr ? isr : irr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      mask <= 8'hFF;
      irr <= '0;
      isr <= '0;
      base <= '0;
      casc <= '0;
      prev <= '0;
      level <= 1'b0;
      single <= 1'b0;
      need_mode <= 1'b0;
      aeoi <= 1'b0;
      master <= 1'b0;
      rd_isr <= 1'b0;
      vec_out <= '0;
      vec_valid <= 1'b0;
    end else begin
      prev <= irq_in;
      vec_valid <= ack && running;
      if (ack && running) vec_out <= take ? base + {5'd0, win} : base + 8'd7;

      if (init_go) begin
        irr <= '0;
        isr <= '0;
      end else begin
        irr <= (level ? irq_in : ((irr | rise) & irq_in)) & ~irr_clr;
        isr <= (isr & ~eoi_clr) | isr_set;
      end

      if (cmd_sel && bus_wdata[1]) rd_isr <= bus_wdata[0];

      if (init_go) begin
        st <= S_BASE;
        level <= bus_wdata[3];
        single <= bus_wdata[1];
        need_mode <= bus_wdata[0];
        aeoi <= 1'b0;
        master <= 1'b0;
        casc <= '0;
        rd_isr <= 1'b0;
      end else if (wr1) begin
        case (st)
          S_BASE: begin
            base <= bus_wdata;
            st <= !single ? S_CASC : (need_mode ? S_MODE : S_RUN);
          end
          S_CASC: begin
            casc <= bus_wdata;
            st <= need_mode ? S_MODE : S_RUN;
          end
          S_MODE: begin
            aeoi <= bus_wdata[1];
            master <= bus_wdata[2];
            st <= S_RUN;
          end
          default: mask <= bus_wdata;
        endcase
      end
    end
  end

  p_quiet_uninit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !int_out);

  p_vec_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack));

  p_one_isr_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out && !aeoi && !bus_wr) |=> ($countones(isr) == $past($countones(isr)) + 1));

  p_auto_eoi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && aeoi && !bus_wr) |=> $stable(isr));

  p_spurious_vec_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !$past(int_out)) |-> (vec_out == base + 8'd7));

  p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~mask) != 8'd0));

endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic       clk = 0, rst_n = 0;
  logic [7:0] irq_in = 0;
  logic       bus_addr = 0, bus_wr = 0, ack = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata, vec_out, cascade_map;
  logic       int_out, vec_valid, ready, is_master;
  logic [2:0] slave_id;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && vec_valid) begin
    if (exp_q.size() == 0) chk("R6 unexpected vector", vec_out, 8'hxx);
    else chk("R6 vector", vec_out, exp_q.pop_front());
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic ack_exp(input logic [7:0] v);
    exp_q.push_back(v);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    @(negedge clk);
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  logic [7:0] r;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(1, r); chk("R1 mask", r, 8'hFF);
    rd(0, r); chk("R1 irr", r, 8'h00);
    chk("R1 int/ready/valid", {5'd0, int_out, ready, vec_valid}, 8'h00);

    wr(1, 8'h00);
    set_irq(8'h01);
    chk("R2 uninit quiet", {7'd0, int_out}, 8'h00);
    set_irq(8'h00);

    wr(0, 8'h11); wr(1, 8'h20);
    chk("R2 not ready mid-init", {7'd0, ready}, 8'h00);
    wr(1, 8'h04); wr(1, 8'h05);
    chk("R2 ready", {7'd0, ready}, 8'h01);
    chk("R3 master map", cascade_map, 8'h04);
    chk("R3 master flag", {7'd0, is_master}, 8'h01);

    wr(1, 8'h00);
    set_irq(8'h28);
    chk("R12 edge latched", {7'd0, int_out}, 8'h01);
    ack_exp(8'h23);
    wr(0, 8'h0B);
    rd(0, r); chk("R6 isr after ack", r, 8'h08);
    chk("R5 lower line blocked", {7'd0, int_out}, 8'h00);
    set_irq(8'h2A);
    chk("R5 higher line nests", {7'd0, int_out}, 8'h01);
    ack_exp(8'h21);
    rd(0, r); chk("R6 nested isr", r, 8'h0A);
    wr(0, 8'h61);
    rd(0, r); chk("R8 specific eoi", r, 8'h08);
    chk("R10 isr select persists", r, 8'h08);
    wr(0, 8'h20);
    rd(0, r); chk("R9 general eoi", r, 8'h00);
    chk("R5 line 5 now allowed", {7'd0, int_out}, 8'h01);
    ack_exp(8'h25);
    wr(0, 8'h65);
    chk("R12 held line no rerequest", {7'd0, int_out}, 8'h00);
    set_irq(8'h00);

    wr(1, 8'h10);
    set_irq(8'h10);
    chk("R4 masked quiet", {7'd0, int_out}, 8'h00);
    rd(1, r); chk("R4 mask readback", r, 8'h10);
    wr(0, 8'h0A);
    rd(0, r); chk("R10 irr select", r, 8'h10);
    wr(1, 8'h00);
    chk("R4 unmasked", {7'd0, int_out}, 8'h01);
    ack_exp(8'h24);
    wr(0, 8'h64);
    set_irq(8'h00);

    set_irq(8'h04);
    chk("R12 edge request", {7'd0, int_out}, 8'h01);
    set_irq(8'h00);
    chk("R12 request lost", {7'd0, int_out}, 8'h00);
    wr(1, 8'hFF);
    ack_exp(8'h27);
    wr(0, 8'h0B);
    rd(0, r); chk("R11 spurious no isr", r, 8'h00);

    wr(0, 8'h11); wr(1, 8'h70); wr(1, 8'h02); wr(1, 8'h01);
    chk("R3 slave id", {5'd0, slave_id}, 8'h02);
    chk("R3 slave map", cascade_map, 8'h00);
    chk("R3 slave flag", {7'd0, is_master}, 8'h00);

    wr(0, 8'h1B); wr(1, 8'h40); wr(1, 8'h03);
    wr(1, 8'h00);
    set_irq(8'h40);
    ack_exp(8'h46);
    wr(0, 8'h0B);
    rd(0, r); chk("R7 auto eoi no isr", r, 8'h00);
    chk("R12 level still requests", {7'd0, int_out}, 8'h01);
    set_irq(8'h00);
    chk("R12 level follows line", {7'd0, int_out}, 8'h00);

    repeat (3) @(negedge clk);
    chk("R6 all vectors seen", 8'(exp_q.size()), 8'h00);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule